// File: doc/BRIEF.md
# Programmable Path Stack Detector

This block watches the stream of retired branches from a processor and cuts it into program paths. Each branch record enters a four-deep input queue. The record carries a type code, a target address, a taken bit, an unconditional flag and an event count. A stack of in-progress paths keeps one entry per active scope. Each branch applies a software-chosen mix of four stack operations to that stack. When a path ends, its descriptor leaves the block over a valid/ready channel. The descriptor holds the start address, the length in branches, one outcome bit per branch and an event total.

A control word sets which operations each branch type performs. A mode field can let a path run on past loop back-edges or procedure calls before it ends. It does this through an extension counter kept in each stack entry. Paths that reach the length limit are split. A push onto a full stack silently drops the oldest entry. A synchronous flush empties the stack.

Top module: `path_stack_detector`

## Requirements
- R1: A record is accepted on any cycle with `br_valid` high and `br_full` low. `br_full` is high exactly while the queue holds 4 unprocessed records. Records are processed in arrival order.
- R2: Type codes are 0 call, 1 return, 2 forward, 3 backward and 4 indirect. `cfg_map[4*t +: 4]` selects the operations for type t: bit 0 update, bit 1 update-count, bit 2 pop, bit 3 push. Codes 5 to 7 change nothing.
- R3: A push creates a new top entry. Its start equals the branch target, and its length, outcomes, event total and extension counter are zero.
- R4: An update on a non-empty stack increments the top length and sets outcome bit at index old-length to 1 if the branch is taken or unconditional, else 0. It also adds the branch event count. Outcome bits at or above the length stay 0.
- R5: An update-count adds only the event count. If both bits 0 and 1 are set, only the update is performed.
- R6: Operations run as update/update-count, then pop, then push. A pop presents the top entry on `path_valid` and holds it unchanged until `path_ready` is high.
- R7: An update on a path already holding 32 branches adds the event count and records no outcome. It then pops that path and pushes an empty path at the branch target, replacing the type's own pop and push.
- R8: With `cfg_mode`=1, a backward branch whose top extension counter is below `cfg_max_ext` only updates and increments the counter. Otherwise the mapped operations apply.
- R9: With `cfg_mode`=2 and a non-empty stack, a call whose top counter differs from the maximum skips pop and push and increments the counter. A return with a nonzero counter skips pop and push and decrements it. Otherwise the mapped operations apply.
- R10: A push onto a stack holding 32 entries discards the oldest entry. The other 31 entries and the new one remain.
- R11: A pop on an empty stack emits nothing, and update operations on an empty stack are ignored.
- R12: The event total saturates at 255.
- R13: `flush` empties the stack and abandons the record in progress.
- R14: After reset `path_valid` and `br_full` are low and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear the whole stack |
| br_valid | input | 1 | Branch record offered |
| br_type | input | 3 | Branch type code |
| br_target | input | ADDR_W | Branch target address |
| br_taken | input | 1 | Branch taken outcome |
| br_uncond | input | 1 | Branch is unconditional |
| br_evt | input | EVT_W | Events since previous branch |
| br_full | output | 1 | Input queue full, stall producer |
| cfg_map | input | 20 | Per-type operation selection |
| cfg_mode | input | 2 | 0 none, 1 loop extension, 2 call extension |
| cfg_max_ext | input | EXT_W | Maximum extension count |
| path_valid | output | 1 | Completed path presented |
| path_ready | input | 1 | Downstream accepts path |
| path_start | output | ADDR_W | Path start address |
| path_len | output | LEN_W | Branches in path |
| path_outcomes | output | MAX_LEN | Outcome bit per branch |
| path_evt | output | EVT_W | Accumulated event total |

## Verification
The main function is driven with call/forward/return sequences, which check outcome recording and update-count against update. Backward branches then tell a termination-and-restart apart from a plain update. Both extension modes are run with small maxima, so the cycle where the counter reaches its limit separates extension from default behaviour. Long runs of 33 forwards and 33 nested calls reach the split and overflow boundaries. Held-off ready and flush show that the output holds and that the stack is discarded.

// File: rtl/path_pkg.sv
package path_pkg;

    localparam int NUM_TYPES = 5;
    localparam int OPF_W     = 4;

    typedef enum logic [2:0] {
        BR_CALL = 3'd0,
        BR_RET  = 3'd1,
        BR_FWD  = 3'd2,
        BR_BWD  = 3'd3,
        BR_IND  = 3'd4
    } br_type_e;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_LOOP = 2'd1,
        EXT_CALL = 2'd2
    } ext_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UPD  = 2'd1,
        ST_POP  = 2'd2,
        ST_PUSH = 2'd3
    } fsm_e;

    typedef struct packed {
        logic upd;
        logic cnt;
        logic pop;
        logic push;
        logic ext_inc;
        logic ext_dec;
    } stack_ops_t;

endpackage

// File: rtl/br_fifo.sv
module br_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          full,
    input  logic          out_take,
    output logic          out_empty,
    output logic [DW-1:0] out_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_ctl_t;

    fifo_ctl_t   ctl_d, ctl_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full      = (ctl_q.cnt == CW'(DEPTH));
    assign out_empty = (ctl_q.cnt == '0);
    assign out_data  = mem_q[ctl_q.rd];
    assign level     = ctl_q.cnt;

    always_comb begin
        ctl_d   = ctl_q;
        mem_d   = mem_q;
        do_push = in_valid && !full;
        do_pop  = out_take && !out_empty;
        if (do_push) begin
            mem_d[ctl_q.wr] = in_data;
            ctl_d.wr = (ctl_q.wr == PW'(DEPTH - 1)) ? '0 : ctl_q.wr + 1'b1;
        end
        if (do_pop) begin
            ctl_d.rd = (ctl_q.rd == PW'(DEPTH - 1)) ? '0 : ctl_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/br_op_decode.sv
module br_op_decode
    import path_pkg::*;
#(
    parameter int EXT_W = 4
) (
    input  logic [2:0]                   br_type,
    input  logic [NUM_TYPES*OPF_W-1:0]   cfg_map,
    input  logic [1:0]                   cfg_mode,
    input  logic [EXT_W-1:0]             cfg_max_ext,
    input  logic [EXT_W-1:0]             top_ext,
    input  logic                         top_valid,
    output stack_ops_t                   ops
);
    logic [OPF_W-1:0] fld;

    always_comb begin
        fld = '0;
        if (br_type < 3'(NUM_TYPES)) fld = cfg_map[{br_type, 2'b00} +: OPF_W];
        ops         = '0;
        ops.upd     = fld[0];
        ops.cnt     = fld[1] & ~fld[0];
        ops.pop     = fld[2];
        ops.push    = fld[3];
        if (top_valid) begin
            if (cfg_mode == EXT_LOOP && br_type == BR_BWD && top_ext < cfg_max_ext) begin
                ops         = '0;
                ops.upd     = 1'b1;
                ops.ext_inc = 1'b1;
            end else if (cfg_mode == EXT_CALL && br_type == BR_CALL && top_ext != cfg_max_ext) begin
                ops.pop     = 1'b0;
                ops.push    = 1'b0;
                ops.ext_inc = 1'b1;
            end else if (cfg_mode == EXT_CALL && br_type == BR_RET && top_ext != '0) begin
                ops.pop     = 1'b0;
                ops.push    = 1'b0;
                ops.ext_dec = 1'b1;
            end
        end
    end
endmodule

// File: rtl/path_stack_store.sv
module path_stack_store #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    logic [W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/path_stack_detector.sv
module path_stack_detector
    import path_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_LEN    = 32,
    parameter int EVT_W      = 8,
    parameter int EXT_W      = 4,
    parameter int DEPTH      = 32,
    parameter int FIFO_DEPTH = 4,
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int MAP_W     = NUM_TYPES * OPF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               br_valid,
    input  logic [2:0]         br_type,
    input  logic [ADDR_W-1:0]  br_target,
    input  logic               br_taken,
    input  logic               br_uncond,
    input  logic [EVT_W-1:0]   br_evt,
    output logic               br_full,
    input  logic [MAP_W-1:0]   cfg_map,
    input  logic [1:0]         cfg_mode,
    input  logic [EXT_W-1:0]   cfg_max_ext,
    output logic               path_valid,
    input  logic               path_ready,
    output logic [ADDR_W-1:0]  path_start,
    output logic [LEN_W-1:0]   path_len,
    output logic [MAX_LEN-1:0] path_outcomes,
    output logic [EVT_W-1:0]   path_evt
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]  start;
        logic [LEN_W-1:0]   len;
        logic [MAX_LEN-1:0] outc;
        logic [EVT_W-1:0]   evt;
        logic [EXT_W-1:0]   ext;
    } entry_t;

    typedef struct packed {
        logic [2:0]        btype;
        logic [ADDR_W-1:0] target;
        logic              taken;
        logic              uncond;
        logic [EVT_W-1:0]  evt;
    } rec_t;

    localparam int ENT_W = $bits(entry_t);
    localparam int REC_W = $bits(rec_t);

    typedef struct packed {
        fsm_e             st;
        rec_t             rec;
        stack_ops_t       ops;
        logic [PTR_W-1:0] base;
        logic [CNT_W-1:0] count;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // input queue
    logic              fifo_take, fifo_empty;
    logic [REC_W-1:0]  fifo_out;
    logic [FCNT_W-1:0] fifo_level;
    rec_t              head;

    br_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (br_valid),
        .in_data   ({br_type, br_target, br_taken, br_uncond, br_evt}),
        .full      (br_full),
        .out_take  (fifo_take),
        .out_empty (fifo_empty),
        .out_data  (fifo_out),
        .level     (fifo_level)
    );
    assign head = rec_t'(fifo_out);

    // stack storage
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, top_idx, push_idx;
    entry_t           wr_data, top;
    logic [ENT_W-1:0] rd_raw;
    logic             top_valid;
    logic [CNT_W-1:0] stk_count;

    assign top_idx   = ctl_q.base + PTR_W'(ctl_q.count) - 1'b1;
    assign push_idx  = ctl_q.base + PTR_W'(ctl_q.count);
    assign top_valid = (ctl_q.count != '0);
    assign stk_count = ctl_q.count;

    path_stack_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx),
        .rd_data (rd_raw)
    );
    assign top = entry_t'(rd_raw);

    // operation selection for the record at the queue head
    stack_ops_t dec_ops;

    br_op_decode #(.EXT_W(EXT_W)) u_dec (
        .br_type     (head.btype),
        .cfg_map     (cfg_map),
        .cfg_mode    (cfg_mode),
        .cfg_max_ext (cfg_max_ext),
        .top_ext     (top.ext),
        .top_valid   (top_valid),
        .ops         (dec_ops)
    );

    // saturating event sum
    logic [EVT_W:0]   evt_sum;
    logic [EVT_W-1:0] evt_sat;
    assign evt_sum = {1'b0, top.evt} + {1'b0, ctl_q.rec.evt};
    assign evt_sat = evt_sum[EVT_W] ? '1 : evt_sum[EVT_W-1:0];

    function automatic fsm_e after_upd(input stack_ops_t o);
        if (o.pop)       return ST_POP;
        else if (o.push) return ST_PUSH;
        else             return ST_IDLE;
    endfunction

    function automatic fsm_e first_step(input stack_ops_t o);
        if (o.upd || o.cnt || o.ext_inc || o.ext_dec) return ST_UPD;
        else                                          return after_upd(o);
    endfunction

    entry_t upd_e;
    logic   obit;

    always_comb begin
        ctl_d     = ctl_q;
        wr_en     = 1'b0;
        wr_idx    = top_idx;
        wr_data   = top;
        fifo_take = 1'b0;
        upd_e     = top;
        obit      = ctl_q.rec.taken | ctl_q.rec.uncond;

        case (ctl_q.st)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_take = 1'b1;
                    ctl_d.rec = head;
                    ctl_d.ops = dec_ops;
                    ctl_d.st  = first_step(dec_ops);
                end
            end
            ST_UPD: begin
                if (top_valid) begin
                    if (ctl_q.ops.upd) begin
                        upd_e.evt = evt_sat;
                        if (top.len == LEN_W'(MAX_LEN)) begin
                            ctl_d.ops.pop  = 1'b1;
                            ctl_d.ops.push = 1'b1;
                        end else begin
                            upd_e.len  = top.len + 1'b1;
                            upd_e.outc = top.outc | (MAX_LEN'(obit) << top.len);
                        end
                    end else if (ctl_q.ops.cnt) begin
                        upd_e.evt = evt_sat;
                    end
                    if (ctl_q.ops.ext_inc)      upd_e.ext = top.ext + 1'b1;
                    else if (ctl_q.ops.ext_dec) upd_e.ext = top.ext - 1'b1;
                    wr_en   = 1'b1;
                    wr_data = upd_e;
                end
                ctl_d.st = after_upd(ctl_d.ops);
            end
            ST_POP: begin
                if (!top_valid) begin
                    ctl_d.st = ctl_q.ops.push ? ST_PUSH : ST_IDLE;
                end else if (path_ready) begin
                    ctl_d.count = ctl_q.count - 1'b1;
                    ctl_d.st    = ctl_q.ops.push ? ST_PUSH : ST_IDLE;
                end
            end
            ST_PUSH: begin
                wr_en         = 1'b1;
                wr_idx        = push_idx;
                wr_data       = '0;
                wr_data.start = ctl_q.rec.target;
                if (ctl_q.count == CNT_W'(DEPTH)) ctl_d.base  = ctl_q.base + 1'b1;
                else                              ctl_d.count = ctl_q.count + 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (flush) begin
            ctl_d.st    = ST_IDLE;
            ctl_d.count = '0;
            ctl_d.base  = '0;
            wr_en       = 1'b0;
            fifo_take   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign path_valid    = (ctl_q.st == ST_POP) && top_valid;
    assign path_start    = top.start;
    assign path_len      = top.len;
    assign path_outcomes = top.outc;
    assign path_evt      = top.evt;

endmodule

// File: rtl/path_stack_chk.sv
module path_stack_chk #(
    parameter int ADDR_W     = 32,
    parameter int MAX_LEN    = 32,
    parameter int EVT_W      = 8,
    parameter int DEPTH      = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int LEN_W      = 6,
    parameter int CNT_W      = 6,
    parameter int FCNT_W     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               path_valid,
    input logic               path_ready,
    input logic [ADDR_W-1:0]  path_start,
    input logic [LEN_W-1:0]   path_len,
    input logic [MAX_LEN-1:0] path_outcomes,
    input logic [EVT_W-1:0]   path_evt,
    input logic [CNT_W-1:0]   stk_count,
    input logic [FCNT_W-1:0]  fifo_level
);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (path_valid && !path_ready) |=> (path_valid && $stable(path_start) && $stable(path_len)
                                         && $stable(path_outcomes) && $stable(path_evt)));

    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid |-> (path_len <= LEN_W'(MAX_LEN)));

    assert_outc_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid |-> ((path_outcomes >> path_len) == '0));

    assert_empty_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_count == '0) |-> !path_valid);

    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= CNT_W'(DEPTH));

    assert_queue_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= FCNT_W'(FIFO_DEPTH));

    assert_flush_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stk_count == '0));
endmodule

bind path_stack_detector path_stack_chk #(
    .ADDR_W     (ADDR_W),
    .MAX_LEN    (MAX_LEN),
    .EVT_W      (EVT_W),
    .DEPTH      (DEPTH),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W),
    .FCNT_W     (FCNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .path_valid    (path_valid),
    .path_ready    (path_ready),
    .path_start    (path_start),
    .path_len      (path_len),
    .path_outcomes (path_outcomes),
    .path_evt      (path_evt),
    .stk_count     (stk_count),
    .fifo_level    (fifo_level)
);

// File: tb/path_stack_detector_tb.sv
module path_stack_detector_tb;
    localparam logic [19:0] MAP_DEF = 20'hDD16A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_type = '0;
    logic [31:0] br_target = '0;
    logic        br_taken = 1'b0;
    logic        br_uncond = 1'b0;
    logic [7:0]  br_evt = '0;
    logic        br_full;
    logic [19:0] cfg_map = MAP_DEF;
    logic [1:0]  cfg_mode = 2'd0;
    logic [3:0]  cfg_max_ext = 4'd0;
    logic        path_valid;
    logic        path_ready = 1'b1;
    logic [31:0] path_start;
    logic [5:0]  path_len;
    logic [31:0] path_outcomes;
    logic [7:0]  path_evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] g_start [64];
    logic [5:0]  g_len   [64];
    logic [31:0] g_outc  [64];
    logic [7:0]  g_evt   [64];
    int          n_got = 0;

    always #5 clk = ~clk;

    path_stack_detector u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .br_valid(br_valid), .br_type(br_type), .br_target(br_target),
        .br_taken(br_taken), .br_uncond(br_uncond), .br_evt(br_evt),
        .br_full(br_full), .cfg_map(cfg_map), .cfg_mode(cfg_mode),
        .cfg_max_ext(cfg_max_ext), .path_valid(path_valid), .path_ready(path_ready),
        .path_start(path_start), .path_len(path_len),
        .path_outcomes(path_outcomes), .path_evt(path_evt)
    );

    always @(negedge clk) begin
        if (rst_n && path_valid && path_ready && n_got < 64) begin
            g_start[n_got] = path_start;
            g_len[n_got]   = path_len;
            g_outc[n_got]  = path_outcomes;
            g_evt[n_got]   = path_evt;
            n_got++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_path(input int idx, input logic [31:0] st, input logic [5:0] ln,
                              input logic [31:0] oc, input logic [7:0] ev, input string req);
        if (idx >= n_got) begin
            check(1'b0, {req, " missing path"}, 64'(n_got), 64'(idx + 1));
        end else begin
            check(g_start[idx] == st, {req, " start"}, 64'(g_start[idx]), 64'(st));
            check(g_len[idx] == ln,   {req, " len"},   64'(g_len[idx]),   64'(ln));
            check(g_outc[idx] == oc,  {req, " outc"},  64'(g_outc[idx]),  64'(oc));
            check(g_evt[idx] == ev,   {req, " evt"},   64'(g_evt[idx]),   64'(ev));
        end
    endtask

    task automatic send(input logic [2:0] t, input logic [31:0] tgt, input bit tk,
                        input bit un, input logic [7:0] ev);
        @(negedge clk);
        while (br_full) @(negedge clk);
        br_valid = 1'b1; br_type = t; br_target = tgt;
        br_taken = tk; br_uncond = un; br_evt = ev;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_case(input logic [19:0] m, input logic [1:0] md, input logic [3:0] mx);
        @(negedge clk);
        cfg_map = m; cfg_mode = md; cfg_max_ext = mx; path_ready = 1'b1;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        n_got = 0;
    endtask

    task automatic t_reset;
        check(path_valid == 1'b0, "R14 valid after reset", 64'(path_valid), 64'd0);
        check(br_full == 1'b0, "R14 full after reset", 64'(br_full), 64'd0);
    endtask

    task automatic t_intra;
        start_case(MAP_DEF, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd3);
        send(3'd2, 32'hA010, 1, 0, 8'd2);
        send(3'd2, 32'hA020, 0, 0, 8'd4);
        send(3'd2, 32'hA030, 0, 1, 8'd0);
        send(3'd1, 32'hB000, 1, 1, 8'd5);
        send(3'd1, 32'hB100, 1, 1, 8'd1);
        settle(40);
        check(n_got == 1, "R11 empty pop silent", 64'(n_got), 64'd1);
        check_path(0, 32'hA000, 6'd3, 32'h5, 8'd11, "R3 R4 R5 call-fwd-return");
    endtask

    task automatic t_backward;
        start_case(MAP_DEF, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd2, 32'hA010, 1, 0, 8'd1);
        send(3'd3, 32'hC000, 1, 0, 8'd2);
        send(3'd1, 32'hD000, 1, 1, 8'd0);
        settle(40);
        check(n_got == 2, "R6 backward count", 64'(n_got), 64'd2);
        check_path(0, 32'hA000, 6'd2, 32'h3, 8'd3, "R6 update before pop");
        check_path(1, 32'hC000, 6'd0, 32'h0, 8'd0, "R6 push after pop");
    endtask

    task automatic t_remap;
        start_case(20'hDD36A, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd2, 32'hA010, 1, 0, 8'd7);
        send(3'd6, 32'hEEEE, 1, 0, 8'd9);
        send(3'd5, 32'hEEE0, 1, 1, 8'd9);
        send(3'd1, 32'hD000, 1, 1, 8'd0);
        settle(40);
        check(n_got == 1, "R2 unused codes no effect", 64'(n_got), 64'd1);
        check_path(0, 32'hA000, 6'd1, 32'h1, 8'd7, "R5 both bits update only");
    endtask

    task automatic t_saturate;
        start_case(MAP_DEF, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd2, 32'hA010, 1, 0, 8'd200);
        send(3'd2, 32'hA020, 1, 0, 8'd100);
        send(3'd1, 32'hD000, 1, 1, 8'd9);
        settle(40);
        check_path(0, 32'hA000, 6'd2, 32'h3, 8'd255, "R12 event saturate");
    endtask

    task automatic t_split;
        start_case(MAP_DEF, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        for (int i = 0; i < 32; i++) send(3'd2, 32'hA100 + i, 1, 0, 8'd1);
        send(3'd2, 32'hC800, 1, 0, 8'd1);
        send(3'd1, 32'hD000, 1, 1, 8'd0);
        settle(60);
        check(n_got == 2, "R7 split count", 64'(n_got), 64'd2);
        check_path(0, 32'hA000, 6'd32, 32'hFFFF_FFFF, 8'd33, "R7 full path");
        check_path(1, 32'hC800, 6'd0, 32'h0, 8'd0, "R7 restart at target");
    endtask

    task automatic t_loop_ext;
        start_case(MAP_DEF, 2'd1, 4'd2);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd3, 32'hB100, 1, 0, 8'd1);
        send(3'd3, 32'hB200, 1, 0, 8'd1);
        send(3'd3, 32'hB300, 1, 0, 8'd1);
        send(3'd1, 32'hD000, 1, 1, 8'd0);
        settle(40);
        check(n_got == 2, "R8 loop ext count", 64'(n_got), 64'd2);
        check_path(0, 32'hA000, 6'd3, 32'h7, 8'd3, "R8 extended loop path");
        check_path(1, 32'hB300, 6'd0, 32'h0, 8'd0, "R8 after max");
    endtask

    task automatic t_call_ext;
        start_case(MAP_DEF, 2'd2, 4'd1);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd0, 32'hB000, 1, 1, 8'd2);
        send(3'd2, 32'hA010, 1, 0, 8'd1);
        send(3'd0, 32'hD000, 1, 1, 8'd1);
        send(3'd1, 32'hE000, 1, 1, 8'd0);
        send(3'd1, 32'hE100, 1, 1, 8'd4);
        send(3'd1, 32'hE200, 1, 1, 8'd0);
        settle(40);
        check(n_got == 2, "R9 call ext count", 64'(n_got), 64'd2);
        check_path(0, 32'hD000, 6'd0, 32'h0, 8'd0, "R9 call at max pushes");
        check_path(1, 32'hA000, 6'd1, 32'h1, 8'd8, "R9 inter-procedural path");
    endtask

    task automatic t_overflow;
        start_case(MAP_DEF, 2'd0, 4'd0);
        for (int i = 0; i < 33; i++) send(3'd0, 32'd100 + i, 1, 1, 8'd0);
        for (int i = 0; i < 33; i++) send(3'd1, 32'hF000, 1, 1, 8'd0);
        settle(80);
        check(n_got == 32, "R10 overflow emitted", 64'(n_got), 64'd32);
        check_path(0, 32'd132, 6'd0, 32'h0, 8'd0, "R10 newest first");
        check_path(31, 32'd101, 6'd0, 32'h0, 8'd0, "R10 oldest dropped");
    endtask

    task automatic t_backpressure;
        logic [31:0] held;
        start_case(MAP_DEF, 2'd0, 4'd0);
        path_ready = 1'b0;
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd1, 32'hD000, 1, 1, 8'd6);
        settle(10);
        check(path_valid == 1'b1, "R6 valid while stalled", 64'(path_valid), 64'd1);
        held = path_start;
        check(held == 32'hA000, "R6 start presented", 64'(held), 64'hA000);
        for (int i = 0; i < 4; i++) send(3'd2, 32'hA100 + i, 1, 0, 8'd1);
        settle(3);
        check(br_full == 1'b1, "R1 full at four", 64'(br_full), 64'd1);
        check(path_start == held && path_valid, "R6 held stable", 64'(path_start), 64'(held));
        check(n_got == 0, "R6 nothing accepted", 64'(n_got), 64'd0);
        path_ready = 1'b1;
        settle(40);
        check(br_full == 1'b0, "R1 drained", 64'(br_full), 64'd0);
        check(n_got == 1, "R1 stale records ignored", 64'(n_got), 64'd1);
        check_path(0, 32'hA000, 6'd0, 32'h0, 8'd6, "R6 after release");
    endtask

    task automatic t_flush;
        start_case(MAP_DEF, 2'd0, 4'd0);
        send(3'd0, 32'hA000, 1, 1, 8'd0);
        send(3'd0, 32'hB000, 1, 1, 8'd0);
        settle(10);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        send(3'd1, 32'hD000, 1, 1, 8'd0);
        send(3'd1, 32'hD100, 1, 1, 8'd0);
        settle(30);
        check(n_got == 0, "R13 flush empties stack", 64'(n_got), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_intra();
        t_backward();
        t_remap();
        t_saturate();
        t_split();
        t_loop_ext();
        t_call_ext();
        t_overflow();
        t_backpressure();
        t_flush();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule